// File: doc/BRIEF.md
# Effective Address Generator for a Multi-Width Processor Core

This block forms the memory offset and the segment choice for a load or store in a core that runs in 16-, 32- or 64-bit operating modes. Each request supplies the mode and, when used, a base register (number and value) and an index register (number and value). It also supplies a 2-bit scale code for the index, a signed displacement with a size code, a flag for instruction-pointer-relative addressing, the next-instruction address and an optional segment override. The block checks that the register choice is permitted in the mode. It adds the terms, wraps the sum to the mode's width and picks the segment. The result is registered and returned one cycle later.

Register numbering is 4-bit: 0 accumulator, 3 BX, 4 stack pointer (SP), 5 frame pointer (BP), 6 SI, 7 DI, 8-15 the extended registers. Segment codes are 3-bit: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. The mode code is 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = reserved. The displacement size code is 0 = none, 1 = 8-bit, 2 = 16-bit, 3 = 32-bit.

The output stage is a two-state machine. It moves to OUT_ISSUE on any cycle with `in_valid` high and to OUT_IDLE on any cycle with `in_valid` low. Reset forces OUT_IDLE. `out_valid` is high exactly in OUT_ISSUE.

Top module: `agu_top`

## Requirements
- R1: A legal request yields base value + (index value × scale factor) + sign-extended displacement; a term whose enable is low contributes zero.
- R2: The scale code k multiplies the index only, by 2^k (1, 2, 4, 8); a nonzero scale code in mode 0 (16-bit) makes the request illegal.
- R3: In mode 0 the base must be register 3 or 5 and the index register 6 or 7; any other number, or displacement size code 3, is illegal.
- R4: In mode 1 (32-bit) the base may be any register 0-7, including 4; the index may be 0-7 except 4; registers 8-15 are illegal for either.
- R5: In mode 2 (64-bit) any of the registers 0-15 may be the base; an index of register 4 is illegal in every mode.
- R6: The displacement is sign-extended from bit 7 (size code 1), bit 15 (size code 2) or bit 31 (size code 3); size code 0 contributes zero.
- R7: Without an override, the segment is SS (code 2) when a base is present and its number is 4 or 5; otherwise, including index-only and displacement-only requests, it is DS (code 3).
- R8: When the override enable is high, the segment output equals the override code whatever the base is.
- R9: In mode 2, with the relative flag set and neither base nor index present, the address is the next-instruction address plus the sign-extended displacement; the flag set in mode 0 or 1, or together with a base or index, is illegal.
- R10: An illegal request returns the illegal flag high and an address of zero.
- R11: The address wraps modulo 2^16 in mode 0 and modulo 2^32 in mode 1, with upper output bits zero; mode code 3 is illegal.
- R12: Outputs appear one clock after the request; `out_valid` equals the previous cycle's `in_valid`, and a synchronous active-high reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Operating mode code |
| in_base_en | input | 1 | Base register present |
| in_base_id | input | 4 | Base register number |
| in_base_val | input | 64 | Base register value |
| in_idx_en | input | 1 | Index register present |
| in_idx_id | input | 4 | Index register number |
| in_idx_val | input | 64 | Index register value |
| in_scale | input | 2 | Index scale code |
| in_disp | input | 32 | Displacement bits |
| in_disp_size | input | 2 | Displacement size code |
| in_rip_rel | input | 1 | Instruction-pointer-relative request |
| in_next_ip | input | 64 | Address of the next instruction |
| in_seg_ovr_en | input | 1 | Segment override present |
| in_seg_ovr | input | 3 | Override segment code |
| out_valid | output | 1 | Result strobe |
| out_ea | output | 64 | Effective address, zero-extended |
| out_seg | output | 3 | Segment code to use |
| out_illegal | output | 1 | Illegal combination flag |

## Verification
The legality check and the segment choice act on the same request in the same cycle. An illegal request must still report the correct default or overridden segment while its address is forced to zero. The bench provokes this with directed requests: a frame-pointer base combined with a scale in 16-bit mode, and a stack-pointer index with an override. Random requests with mixed register numbers do the same. Each output word is judged as a whole against a bench model that computes legality, address and segment separately.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int ADDR_W = 64;
    localparam int DISP_W = 32;
    localparam int RID_W  = 4;
    localparam int SEG_W  = 3;

    typedef enum logic [1:0] {
        MODE_16  = 2'd0,
        MODE_32  = 2'd1,
        MODE_64  = 2'd2,
        MODE_RSV = 2'd3
    } agu_mode_e;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_8    = 2'd1,
        DSZ_16   = 2'd2,
        DSZ_32   = 2'd3
    } disp_size_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_ISSUE = 1'b1
    } out_state_e;

    localparam logic [RID_W-1:0] REG_BX = 4'd3;
    localparam logic [RID_W-1:0] REG_SP = 4'd4;
    localparam logic [RID_W-1:0] REG_BP = 4'd5;
    localparam logic [RID_W-1:0] REG_SI = 4'd6;
    localparam logic [RID_W-1:0] REG_DI = 4'd7;

    localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
    localparam logic [SEG_W-1:0] SEG_DS = 3'd3;

endpackage

// File: rtl/agu_rule_check.sv
module agu_rule_check
    import agu_pkg::*;
#(
    parameter int RID_W_P = RID_W
) (
    input  logic [1:0]         mode,
    input  logic               base_en,
    input  logic [RID_W_P-1:0] base_id,
    input  logic               idx_en,
    input  logic [RID_W_P-1:0] idx_id,
    input  logic [1:0]         scale,
    input  logic [1:0]         dsize,
    input  logic               rip_rel,
    output logic               illegal
);

    localparam int LEGACY_REGS = 8;

    logic base_ext;
    logic idx_ext;

    always_comb begin
        base_ext = (int'(base_id) >= LEGACY_REGS);
        idx_ext  = (int'(idx_id) >= LEGACY_REGS);
    end

    always_comb begin
        illegal = 1'b0;
        unique case (agu_mode_e'(mode))
            MODE_16: begin
                if (base_en && (base_id != REG_BX) && (base_id != REG_BP))
                    illegal = 1'b1;
                if (idx_en && (idx_id != REG_SI) && (idx_id != REG_DI))
                    illegal = 1'b1;
                if (scale != 2'd0)
                    illegal = 1'b1;
                if (disp_size_e'(dsize) == DSZ_32)
                    illegal = 1'b1;
                if (rip_rel)
                    illegal = 1'b1;
            end
            MODE_32: begin
                if (base_en && base_ext)
                    illegal = 1'b1;
                if (idx_en && (idx_ext || (idx_id == REG_SP)))
                    illegal = 1'b1;
                if (rip_rel)
                    illegal = 1'b1;
            end
            MODE_64: begin
                if (idx_en && (idx_id == REG_SP))
                    illegal = 1'b1;
                if (rip_rel && (base_en || idx_en))
                    illegal = 1'b1;
            end
            MODE_RSV: begin
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int DISP_W_P = DISP_W
) (
    input  logic [1:0]          mode,
    input  logic                base_en,
    input  logic [ADDR_W_P-1:0] base_val,
    input  logic                idx_en,
    input  logic [ADDR_W_P-1:0] idx_val,
    input  logic [1:0]          scale,
    input  logic [DISP_W_P-1:0] disp,
    input  logic [1:0]          dsize,
    input  logic                rip_rel,
    input  logic [ADDR_W_P-1:0] next_ip,
    output logic [ADDR_W_P-1:0] ea_raw
);

    localparam int NARROW_W = 16;
    localparam int MID_W    = 32;

    logic [ADDR_W_P-1:0] disp_ext;
    logic [ADDR_W_P-1:0] base_term;
    logic [ADDR_W_P-1:0] idx_term;
    logic [ADDR_W_P-1:0] sum;

    always_comb begin
        unique case (disp_size_e'(dsize))
            DSZ_NONE: disp_ext = '0;
            DSZ_8:    disp_ext = {{(ADDR_W_P-8){disp[7]}}, disp[7:0]};
            DSZ_16:   disp_ext = {{(ADDR_W_P-16){disp[15]}}, disp[15:0]};
            DSZ_32:   disp_ext = {{(ADDR_W_P-DISP_W_P){disp[DISP_W_P-1]}}, disp};
        endcase
    end

    always_comb begin
        if (base_en)
            base_term = base_val;
        else if (rip_rel)
            base_term = next_ip;
        else
            base_term = '0;
        idx_term = idx_en ? (idx_val << scale) : '0;
        sum      = base_term + idx_term + disp_ext;
    end

    always_comb begin
        unique case (agu_mode_e'(mode))
            MODE_16:  ea_raw = {{(ADDR_W_P-NARROW_W){1'b0}}, sum[NARROW_W-1:0]};
            MODE_32:  ea_raw = {{(ADDR_W_P-MID_W){1'b0}}, sum[MID_W-1:0]};
            MODE_64:  ea_raw = sum;
            MODE_RSV: ea_raw = '0;
        endcase
    end

endmodule

// File: rtl/agu_seg_pick.sv
module agu_seg_pick
    import agu_pkg::*;
#(
    parameter int RID_W_P = RID_W,
    parameter int SEG_W_P = SEG_W
) (
    input  logic               ovr_en,
    input  logic [SEG_W_P-1:0] ovr_seg,
    input  logic               base_en,
    input  logic [RID_W_P-1:0] base_id,
    output logic [SEG_W_P-1:0] seg
);

    logic stack_base;

    always_comb begin
        stack_base = base_en && ((base_id == REG_SP) || (base_id == REG_BP));
        if (ovr_en)
            seg = ovr_seg;
        else if (stack_base)
            seg = SEG_SS;
        else
            seg = SEG_DS;
    end

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int DISP_W_P = DISP_W,
    parameter int RID_W_P  = RID_W,
    parameter int SEG_W_P  = SEG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          in_mode,
    input  logic                in_base_en,
    input  logic [RID_W_P-1:0]  in_base_id,
    input  logic [ADDR_W_P-1:0] in_base_val,
    input  logic                in_idx_en,
    input  logic [RID_W_P-1:0]  in_idx_id,
    input  logic [ADDR_W_P-1:0] in_idx_val,
    input  logic [1:0]          in_scale,
    input  logic [DISP_W_P-1:0] in_disp,
    input  logic [1:0]          in_disp_size,
    input  logic                in_rip_rel,
    input  logic [ADDR_W_P-1:0] in_next_ip,
    input  logic                in_seg_ovr_en,
    input  logic [SEG_W_P-1:0]  in_seg_ovr,
    output logic                out_valid,
    output logic [ADDR_W_P-1:0] out_ea,
    output logic [SEG_W_P-1:0]  out_seg,
    output logic                out_illegal
);

    out_state_e          state_q;
    out_state_e          state_d;
    logic                bad_c;
    logic [ADDR_W_P-1:0] ea_c;
    logic [SEG_W_P-1:0]  seg_c;
    logic [ADDR_W_P-1:0] ea_q;
    logic [SEG_W_P-1:0]  seg_q;
    logic                bad_q;

    agu_rule_check #(.RID_W_P(RID_W_P)) u_rules (
        .mode    (in_mode),
        .base_en (in_base_en),
        .base_id (in_base_id),
        .idx_en  (in_idx_en),
        .idx_id  (in_idx_id),
        .scale   (in_scale),
        .dsize   (in_disp_size),
        .rip_rel (in_rip_rel),
        .illegal (bad_c)
    );

    agu_addr_calc #(.ADDR_W_P(ADDR_W_P), .DISP_W_P(DISP_W_P)) u_calc (
        .mode     (in_mode),
        .base_en  (in_base_en),
        .base_val (in_base_val),
        .idx_en   (in_idx_en),
        .idx_val  (in_idx_val),
        .scale    (in_scale),
        .disp     (in_disp),
        .dsize    (in_disp_size),
        .rip_rel  (in_rip_rel),
        .next_ip  (in_next_ip),
        .ea_raw   (ea_c)
    );

    agu_seg_pick #(.RID_W_P(RID_W_P), .SEG_W_P(SEG_W_P)) u_seg (
        .ovr_en  (in_seg_ovr_en),
        .ovr_seg (in_seg_ovr),
        .base_en (in_base_en),
        .base_id (in_base_id),
        .seg     (seg_c)
    );

    // Next-state decode for the output stage
    always_comb begin
        unique case (state_q)
            OUT_IDLE:  state_d = in_valid ? OUT_ISSUE : OUT_IDLE;
            OUT_ISSUE: state_d = in_valid ? OUT_ISSUE : OUT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= OUT_IDLE;
        else
            state_q <= state_d;
    end

    // Result register, captured on every accepted request
    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q  <= '0;
            seg_q <= '0;
            bad_q <= 1'b0;
        end else if (in_valid) begin
            ea_q  <= bad_c ? '0 : ea_c;
            seg_q <= seg_c;
            bad_q <= bad_c;
        end
    end

    // Output process
    always_comb begin
        out_valid   = (state_q == OUT_ISSUE);
        out_ea      = ea_q;
        out_seg     = seg_q;
        out_illegal = bad_q;
    end

endmodule

// File: rtl/agu_top_chk.sv
module agu_top_chk #(
    parameter int ADDR_W_P = 64,
    parameter int RID_W_P  = 4,
    parameter int SEG_W_P  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [1:0]          in_mode,
    input logic                in_idx_en,
    input logic [RID_W_P-1:0]  in_idx_id,
    input logic [1:0]          in_scale,
    input logic                in_seg_ovr_en,
    input logic [SEG_W_P-1:0]  in_seg_ovr,
    input logic                out_valid,
    input logic [ADDR_W_P-1:0] out_ea,
    input logic [SEG_W_P-1:0]  out_seg,
    input logic                out_illegal
);

    p_valid_lat_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    p_zero_ill_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_ea == '0));

    p_wrap16_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && ($past(in_mode) == 2'd0))
            |-> (out_ea[ADDR_W_P-1:16] == '0));

    p_wrap32_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && ($past(in_mode) == 2'd1))
            |-> (out_ea[ADDR_W_P-1:32] == '0));

    p_ovr_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_seg_ovr_en)) |-> (out_seg == $past(in_seg_ovr)));

    p_scale16_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_mode) == 2'd0) && ($past(in_scale) != 2'd0))
            |-> out_illegal);

    p_sp_index_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_idx_en) && ($past(in_idx_id) == 4'd4))
            |-> out_illegal);

endmodule

bind agu_top agu_top_chk #(
    .ADDR_W_P(ADDR_W_P), .RID_W_P(RID_W_P), .SEG_W_P(SEG_W_P)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_mode       (in_mode),
    .in_idx_en     (in_idx_en),
    .in_idx_id     (in_idx_id),
    .in_scale      (in_scale),
    .in_seg_ovr_en (in_seg_ovr_en),
    .in_seg_ovr    (in_seg_ovr),
    .out_valid     (out_valid),
    .out_ea        (out_ea),
    .out_seg       (out_seg),
    .out_illegal   (out_illegal)
);

// File: tb/agu_top_tb.sv
`timescale 1ns/1ps
module agu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_mode;
    logic        in_base_en;
    logic [3:0]  in_base_id;
    logic [63:0] in_base_val;
    logic        in_idx_en;
    logic [3:0]  in_idx_id;
    logic [63:0] in_idx_val;
    logic [1:0]  in_scale;
    logic [31:0] in_disp;
    logic [1:0]  in_disp_size;
    logic        in_rip_rel;
    logic [63:0] in_next_ip;
    logic        in_seg_ovr_en;
    logic [2:0]  in_seg_ovr;
    logic        out_valid;
    logic [63:0] out_ea;
    logic [2:0]  out_seg;
    logic        out_illegal;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    agu_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_base_en(in_base_en), .in_base_id(in_base_id), .in_base_val(in_base_val),
        .in_idx_en(in_idx_en), .in_idx_id(in_idx_id), .in_idx_val(in_idx_val),
        .in_scale(in_scale), .in_disp(in_disp), .in_disp_size(in_disp_size),
        .in_rip_rel(in_rip_rel), .in_next_ip(in_next_ip),
        .in_seg_ovr_en(in_seg_ovr_en), .in_seg_ovr(in_seg_ovr),
        .out_valid(out_valid), .out_ea(out_ea), .out_seg(out_seg),
        .out_illegal(out_illegal)
    );

    // Reference model, written from the requirements
    function automatic bit ref_bad();
        bit b = 1'b0;
        case (in_mode)
            2'd0: begin
                if (in_base_en && !(in_base_id == 4'd3 || in_base_id == 4'd5)) b = 1'b1;
                if (in_idx_en && !(in_idx_id == 4'd6 || in_idx_id == 4'd7)) b = 1'b1;
                if (in_scale != 2'd0 || in_disp_size == 2'd3 || in_rip_rel) b = 1'b1;
            end
            2'd1: begin
                if (in_base_en && in_base_id > 4'd7) b = 1'b1;
                if (in_idx_en && (in_idx_id > 4'd7 || in_idx_id == 4'd4)) b = 1'b1;
                if (in_rip_rel) b = 1'b1;
            end
            2'd2: begin
                if (in_idx_en && in_idx_id == 4'd4) b = 1'b1;
                if (in_rip_rel && (in_base_en || in_idx_en)) b = 1'b1;
            end
            default: b = 1'b1;
        endcase
        return b;
    endfunction

    function automatic logic [63:0] ref_ea();
        logic [63:0] d;
        logic [63:0] s;
        case (in_disp_size)
            2'd1: d = 64'(longint'($signed(in_disp[7:0])));
            2'd2: d = 64'(longint'($signed(in_disp[15:0])));
            2'd3: d = 64'(longint'($signed(in_disp)));
            default: d = 64'd0;
        endcase
        s = d;
        if (in_base_en) s = s + in_base_val;
        else if (in_rip_rel) s = s + in_next_ip;
        if (in_idx_en) s = s + in_idx_val * (64'd1 << in_scale);
        if (ref_bad()) return 64'd0;
        if (in_mode == 2'd0) return s & 64'hFFFF;
        if (in_mode == 2'd1) return s & 64'hFFFF_FFFF;
        return s;
    endfunction

    function automatic logic [2:0] ref_seg();
        if (in_seg_ovr_en) return in_seg_ovr;
        if (in_base_en && (in_base_id == 4'd4 || in_base_id == 4'd5)) return 3'd2;
        return 3'd3;
    endfunction

    task automatic set_req(input logic [1:0] m, input logic be, input logic [3:0] bid,
                           input logic [63:0] bv, input logic ie, input logic [3:0] iid,
                           input logic [63:0] iv, input logic [1:0] sc,
                           input logic [31:0] d, input logic [1:0] ds,
                           input logic rip, input logic [63:0] nip,
                           input logic oe, input logic [2:0] ov);
        in_mode = m; in_base_en = be; in_base_id = bid; in_base_val = bv;
        in_idx_en = ie; in_idx_id = iid; in_idx_val = iv; in_scale = sc;
        in_disp = d; in_disp_size = ds; in_rip_rel = rip; in_next_ip = nip;
        in_seg_ovr_en = oe; in_seg_ovr = ov;
    endtask

    // Drive at a falling edge, result is registered at the next rising edge,
    // sampled at the falling edge after it.
    task automatic issue(input string tag, input logic [63:0] exp_ea_in, input bit use_exp);
        logic [63:0] e_ea;
        logic [2:0]  e_seg;
        bit          e_bad;
        e_ea  = use_exp ? exp_ea_in : ref_ea();
        e_seg = ref_seg();
        e_bad = ref_bad();
        in_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || out_ea !== e_ea || out_seg !== e_seg || out_illegal !== e_bad) begin
            failures++;
            $display("FAIL %s: got v=%0b ea=%h seg=%0d ill=%0b exp v=1 ea=%h seg=%0d ill=%0b",
                     tag, out_valid, out_ea, out_seg, out_illegal, e_ea, e_seg, e_bad);
        end
    endtask

    task automatic chk_idle(input string tag);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s: out_valid got %0b exp 0", tag, out_valid);
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h00C0FFEE);
        rst = 1'b1;
        in_valid = 1'b0;
        set_req(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk_idle("R12 reset");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R12 idle after reset");

        // R1 / R2: 32-bit base + index*4 + disp8
        set_req(2'd1, 1, 4'd3, 64'h1000, 1, 4'd6, 64'h10, 2'd2, 32'h7F, 2'd1, 0, 0, 0, 0);
        issue("R1 R2 sum scaled", 64'h10BF, 1);
        // R6: negative 8-bit displacement, 64-bit
        set_req(2'd2, 1, 4'd0, 64'h100, 0, 0, 0, 0, 32'h80, 2'd1, 0, 0, 0, 0);
        issue("R6 disp8 negative", 64'h80, 1);
        // R6: negative 16-bit displacement, 32-bit, wraps
        set_req(2'd1, 1, 4'd1, 64'h0, 0, 0, 0, 0, 32'h8000, 2'd2, 0, 0, 0, 0);
        issue("R6 disp16 negative", 64'hFFFF_8000, 1);
        // R3 / R11: 16-bit BX+SI wraps
        set_req(2'd0, 1, 4'd3, 64'hFFF0, 1, 4'd6, 64'h20, 0, 0, 0, 0, 0, 0, 0);
        issue("R3 R11 wrap16", 64'h10, 1);
        // R3: accumulator as base in 16-bit
        set_req(2'd0, 1, 4'd0, 64'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R3 bad base16", 64'h0, 1);
        // R3: 32-bit displacement in 16-bit
        set_req(2'd0, 0, 0, 0, 1, 4'd7, 64'h4, 0, 32'h1, 2'd3, 0, 0, 0, 0);
        issue("R3 disp32 in 16", 64'h0, 1);
        // R2 with R7: BP base, scale in 16-bit -> illegal, SS still reported
        set_req(2'd0, 1, 4'd5, 64'h40, 1, 4'd7, 64'h2, 2'd1, 0, 0, 0, 0, 0, 0);
        issue("R2 scale16 illegal", 64'h0, 1);
        // R7: BP+DI in 16-bit -> SS
        set_req(2'd0, 1, 4'd5, 64'h40, 1, 4'd7, 64'h2, 0, 0, 0, 0, 0, 0, 0);
        issue("R7 bp stack", 64'h42, 1);
        // R7 / R4: stack pointer base 32-bit -> SS
        set_req(2'd1, 1, 4'd4, 64'h200, 0, 0, 0, 0, 32'h4, 2'd1, 0, 0, 0, 0);
        issue("R7 R4 sp base", 64'h204, 1);
        // R7 / R5: register 13 as base in 64-bit -> DS
        set_req(2'd2, 1, 4'd13, 64'h1_0000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R7 R5 ext base", 64'h1_0000_0000, 1);
        // R7: index only -> DS
        set_req(2'd1, 0, 0, 0, 1, 4'd5, 64'h3, 2'd3, 0, 0, 0, 0, 0, 0);
        issue("R7 index only", 64'h18, 1);
        // R8: override with BP base
        set_req(2'd0, 1, 4'd5, 64'h8, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd4);
        issue("R8 override", 64'h8, 1);
        // R8 with R5: override on an illegal SP index
        set_req(2'd2, 1, 4'd5, 64'h8, 1, 4'd4, 64'h1, 0, 0, 0, 0, 0, 1, 3'd0);
        issue("R8 R5 override on illegal", 64'h0, 1);
        // R9: relative, negative displacement
        set_req(2'd2, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFF0, 2'd3, 1, 64'h4000, 0, 0);
        issue("R9 rip relative", 64'h3FF0, 1);
        // R9: relative in 32-bit mode is illegal
        set_req(2'd1, 0, 0, 0, 0, 0, 0, 0, 32'h10, 2'd3, 1, 64'h4000, 0, 0);
        issue("R9 rip in 32", 64'h0, 1);
        // R9: relative with a base in 64-bit is illegal
        set_req(2'd2, 1, 4'd1, 64'h5, 0, 0, 0, 0, 32'h10, 2'd3, 1, 64'h4000, 0, 0);
        issue("R9 rip with base", 64'h0, 1);
        // R4: extended register in 32-bit
        set_req(2'd1, 1, 4'd9, 64'h5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R4 ext base32", 64'h0, 1);
        // R10 / R11: reserved mode
        set_req(2'd3, 1, 4'd1, 64'h5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R10 R11 reserved mode", 64'h0, 1);
        // R11: 32-bit wrap from large base
        set_req(2'd1, 1, 4'd2, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 0, 0, 32'h20, 2'd1, 0, 0, 0, 0);
        issue("R11 wrap32", 64'h10, 1);
        // R1: no terms at all, 64-bit absolute zero
        set_req(2'd2, 0, 0, 0, 0, 0, 0, 0, 32'h1234, 2'd0, 0, 0, 0, 0);
        issue("R1 R6 no disp", 64'h0, 1);

        in_valid = 1'b0;
        @(negedge clk);
        chk_idle("R12 valid drop");

        // Random requests, back to back
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] m;
            logic [3:0] bid;
            logic [3:0] iid;
            m = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
            bid = 4'($urandom);
            iid = 4'($urandom);
            if (m == 2'd0 && ($urandom % 4 != 0)) begin
                bid = ($urandom % 2) ? 4'd3 : 4'd5;
                iid = ($urandom % 2) ? 4'd6 : 4'd7;
            end
            set_req(m, 1'($urandom), bid, {$urandom, $urandom}, 1'($urandom), iid,
                    {$urandom, $urandom},
                    (m == 2'd0 && ($urandom % 4 != 0)) ? 2'd0 : 2'($urandom),
                    $urandom, 2'($urandom), ($urandom % 6 == 0),
                    {$urandom, $urandom}, ($urandom % 4 == 0), 3'($urandom % 6));
            issue("R1-mix random", 64'h0, 0);
            if (n % 97 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk_idle("R12 random gap");
            end
        end

        in_valid = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got no finish exp finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule